// File: doc/BRIEF.md
# Multilevel Page Table Walker

This block turns a virtual address into a physical address by descending a fixed-depth radix tree of page tables kept in memory. Every table fills exactly one 4 KB page of 4-byte entries, so each level consumes a 10-bit slice of the virtual address. The most significant slice indexes the top table, whose page is named by a root frame register. The 12-bit page offset passes through untouched. The walker issues one entry read per level through a valid/ready request port, then waits for the response before it decodes the entry.

An entry that is not valid ends the walk at once with a fault, because sub-trees with no mapped addresses are simply absent. An entry that is valid at an inner level points to the next table. At the last level it supplies the frame number, which is joined with the offset to form the result. A write request that reaches a leaf without write permission faults instead. Software reloads the root frame on a context switch. The walker handles one request at a time: it is busy from acceptance until it pulses either done or fault.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready_o` is 1 and `busy_o` is 0. A request is accepted on a cycle with `req_valid_i` and `req_ready_o` both high. From the next cycle `busy_o` is 1 and `req_ready_o` is 0 until the cycle in which the outcome pulses. Requests presented while busy are ignored.
- R2: The read for level L targets {table frame, index L, 2'b00}. Index L is the 10-bit field `vaddr[12+10*(LEVELS-1-L) +: 10]`, so level 0 uses the most significant field. The table frame is the root frame for level 0 and the frame taken from the previous level's entry otherwise.
- R3: The entry format is as follows: bit 0 is valid, bit 1 is writable, and bits 31:12 hold a frame number. Bits 11:2 are ignored.
- R4: Exactly one memory read is issued per level visited. `mem_req_valid_o` and `mem_req_addr_o` stay stable until `mem_req_ready_i` is high. No new read is issued before the response to the previous one arrives, and none is issued while idle.
- R5: After a valid entry at every level, `done_o` pulses for one cycle. In that cycle `paddr_o` = {leaf frame, vaddr[11:0]}, and it holds that value afterwards.
- R6: An invalid entry at level L pulses `fault_o` with `fault_level_o` = L, and no further reads are made for that walk.
- R7: A write request whose leaf entry has writable = 0 faults at level LEVELS-1. A read through the same leaf succeeds. The writable bit of inner entries is not checked.
- R8: A cycle with `root_load_i` high stores `root_frame_i`. A walk uses the root value held when it was accepted, so a load during a walk affects only later walks.
- R9: `done_o` and `fault_o` are never high together, and each is high for a single cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| root_load_i | input | 1 | Load the root frame register |
| root_frame_i | input | PA_W-12 | New root table frame number |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| req_vaddr_i | input | LEVELS*10+12 | Virtual address to translate |
| req_write_i | input | 1 | Request is a write access |
| mem_req_valid_o | output | 1 | Entry read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | PA_W | Byte address of the entry |
| mem_rsp_valid_i | input | 1 | Entry data valid |
| mem_rsp_data_i | input | 32 | Entry data |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse: translation succeeded |
| fault_o | output | 1 | One-cycle pulse: translation faulted |
| paddr_o | output | PA_W | Physical address of the last success |
| fault_level_o | output | LVL_W | Level at which the last fault occurred |

## Verification
The bench builds the walker with LEVELS = 3, which gives a 42-bit virtual address and three reads per walk. This depth puts a middle level within reach, so a fault there can be told apart from faults at the root and at the leaf. It also means an inner entry carries a frame forward twice before the leaf is read. Memory ready stalls and response latency are varied, and the tests also cover a request made while the walker is busy and a root reload in the middle of a walk.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walk_st_e;

  localparam int ENT_VALID_BIT = 0;
  localparam int ENT_WRITE_BIT = 1;
endpackage

// File: rtl/pt_index_sel.sv
module pt_index_sel #(
  parameter int LEVELS = 2,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int LVL_W  = 1,
  localparam int VA_W  = LEVELS * IDX_W + OFF_W
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_a [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    // level 0 takes the most significant field
    assign idx_a[g] = vaddr_i[OFF_W + IDX_W*(LEVELS-1-g) +: IDX_W];
  end

  always_comb begin
    idx_o = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (lvl_i == LVL_W'(l)) idx_o = idx_a[l];
    end
  end

  logic unused_off;
  assign unused_off = ^vaddr_i[OFF_W-1:0];
endmodule

// File: rtl/pt_entry_dec.sv
module pt_entry_dec #(
  parameter int ENTRY_W = 32,
  parameter int OFF_W   = 12,
  parameter int FN_W    = 20
) (
  input  logic [ENTRY_W-1:0] entry_i,
  output logic               valid_o,
  output logic               writable_o,
  output logic [FN_W-1:0]    frame_o
);
  import pt_walk_pkg::*;

  assign valid_o    = entry_i[ENT_VALID_BIT];
  assign writable_o = entry_i[ENT_WRITE_BIT];
  assign frame_o    = entry_i[OFF_W +: FN_W];

  logic unused_rsvd;
  assign unused_rsvd = ^entry_i[OFF_W-1:ENT_WRITE_BIT+1];
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm #(
  parameter int LEVELS = 2,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int FN_W   = 20,
  parameter int LVL_W  = 1,
  localparam int VA_W  = LEVELS * IDX_W + OFF_W,
  localparam int PA_W  = FN_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic             write_i,
  input  logic [FN_W-1:0]  root_i,
  input  logic             mem_ready_i,
  input  logic             rsp_valid_i,
  input  logic             ent_valid_i,
  input  logic             ent_wr_i,
  input  logic [FN_W-1:0]  ent_frame_i,
  output logic             idle_o,
  output logic             mem_valid_o,
  output logic [VA_W-1:0]  va_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic [FN_W-1:0]  tbl_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic [LVL_W-1:0] flvl_o
);
  import pt_walk_pkg::*;

  localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS - 1);

  walk_st_e st_q;
  logic     wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      wr_q    <= 1'b0;
      va_o    <= '0;
      lvl_o   <= '0;
      tbl_o   <= '0;
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      paddr_o <= '0;
      flvl_o  <= '0;
    end else begin
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          va_o  <= vaddr_i;
          wr_q  <= write_i;
          tbl_o <= root_i;
          lvl_o <= '0;
          st_q  <= ST_REQ;
        end
        ST_REQ: if (mem_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          if (!ent_valid_i) begin
            fault_o <= 1'b1;
            flvl_o  <= lvl_o;
            st_q    <= ST_IDLE;
          end else if (lvl_o == LAST) begin
            if (wr_q && !ent_wr_i) begin
              fault_o <= 1'b1;
              flvl_o  <= lvl_o;
            end else begin
              done_o  <= 1'b1;
              paddr_o <= {ent_frame_i, va_o[OFF_W-1:0]};
            end
            st_q <= ST_IDLE;
          end else begin
            tbl_o <= ent_frame_i;
            lvl_o <= lvl_o + LVL_W'(1);
            st_q  <= ST_REQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o      = (st_q == ST_IDLE);
  assign mem_valid_o = (st_q == ST_REQ);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int LEVELS  = 2,
  parameter int OFF_W   = 12,
  parameter int PA_W    = 32,
  parameter int ENTRY_W = 32,
  localparam int ENT_SH = $clog2(ENTRY_W / 8),
  localparam int IDX_W  = OFF_W - ENT_SH,
  localparam int FN_W   = PA_W - OFF_W,
  localparam int VA_W   = LEVELS * IDX_W + OFF_W,
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               root_load_i,
  input  logic [FN_W-1:0]    root_frame_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_vaddr_i,
  input  logic               req_write_i,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic [PA_W-1:0]    mem_req_addr_o,
  input  logic               mem_rsp_valid_i,
  input  logic [ENTRY_W-1:0] mem_rsp_data_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               fault_o,
  output logic [PA_W-1:0]    paddr_o,
  output logic [LVL_W-1:0]   fault_level_o
);
  logic [FN_W-1:0]  root_q;
  logic             idle;
  logic [VA_W-1:0]  va;
  logic [LVL_W-1:0] lvl;
  logic [FN_W-1:0]  tbl;
  logic [IDX_W-1:0] idx;
  logic             ent_valid, ent_wr;
  logic [FN_W-1:0]  ent_frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          root_q <= '0;
    else if (root_load_i) root_q <= root_frame_i;
  end

  pt_index_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .LVL_W(LVL_W)) u_idx (
    .vaddr_i(va), .lvl_i(lvl), .idx_o(idx)
  );

  pt_entry_dec #(.ENTRY_W(ENTRY_W), .OFF_W(OFF_W), .FN_W(FN_W)) u_dec (
    .entry_i(mem_rsp_data_i), .valid_o(ent_valid), .writable_o(ent_wr), .frame_o(ent_frame)
  );

  pt_walk_fsm #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .FN_W(FN_W), .LVL_W(LVL_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(req_valid_i && idle), .vaddr_i(req_vaddr_i), .write_i(req_write_i),
    .root_i(root_q), .mem_ready_i(mem_req_ready_i), .rsp_valid_i(mem_rsp_valid_i),
    .ent_valid_i(ent_valid), .ent_wr_i(ent_wr), .ent_frame_i(ent_frame),
    .idle_o(idle), .mem_valid_o(mem_req_valid_o), .va_o(va), .lvl_o(lvl), .tbl_o(tbl),
    .done_o(done_o), .fault_o(fault_o), .paddr_o(paddr_o), .flvl_o(fault_level_o)
  );

  assign mem_req_addr_o = {tbl, idx, ENT_SH'(0)};
  assign req_ready_o    = idle;
  assign busy_o         = !idle;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_ready_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            fault_o,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic [PA_W-1:0] mem_req_addr_o,
  input logic            mem_rsp_valid_i
);
  p_ready_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o == !busy_o);

  p_idle_at_end_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |-> !busy_o);

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  p_no_req_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_valid_o);

  p_one_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);

  p_done_after_rsp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |-> $past(mem_rsp_valid_i));

  p_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));

  p_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |=> !(done_o || fault_o));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o), .busy_o(busy_o),
  .done_o(done_o), .fault_o(fault_o), .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i), .mem_req_addr_o(mem_req_addr_o),
  .mem_rsp_valid_i(mem_rsp_valid_i)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  localparam int LEVELS = 3;
  localparam int VA_W   = LEVELS * 10 + 12;

  logic clk = 0, rst_n = 0;
  logic root_load = 0;
  logic [19:0] root_frame = '0;
  logic req_valid = 0, req_write = 0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic mem_ready = 1, mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = '0;
  logic req_ready, mem_req_valid, busy, done, fault;
  logic [31:0] mem_addr, paddr;
  logic [1:0] flvl;

  int checks = 0, errors = 0;
  int reads = 0, stall_cfg = 0, stall_left = 0, rsp_lat = 0;
  logic [31:0] rd_addr [8];
  logic [31:0] mem [logic [31:0]];

  always #4 clk = ~clk;

  pt_walker #(.LEVELS(LEVELS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .root_load_i(root_load), .root_frame_i(root_frame),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_ready),
    .mem_req_addr_o(mem_addr), .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
    .busy_o(busy), .done_o(done), .fault_o(fault), .paddr_o(paddr), .fault_level_o(flvl)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [VA_W-1:0] mkva(input int i0, i1, i2, off);
    return {10'(i0), 10'(i1), 10'(i2), 12'(off)};
  endfunction

  function automatic logic [31:0] ent(input logic [19:0] fn, input logic w, input logic v);
    return {fn, 10'h2A5, w, v};  // bits 11:2 filled with junk (R3: ignored)
  endfunction

  task automatic put(input logic [19:0] tbl, input int idx, input logic [31:0] e);
    mem[{tbl, 10'(idx), 2'b00}] = e;
  endtask

  // memory responder
  initial begin
    logic [31:0] a;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (mem_req_valid && stall_left > 0) begin mem_ready = 0; stall_left--; end
      else mem_ready = 1;
      if (mem_req_valid && mem_ready) begin
        a = mem_addr;
        if (reads < 8) rd_addr[reads] = a;
        reads++;
        stall_left = stall_cfg;
        @(negedge clk);
        repeat (rsp_lat) @(negedge clk);
        mem_rsp_valid = 1;
        mem_rsp_data  = mem.exists(a) ? mem[a] : 32'h0;
      end
    end
  end

  task automatic run_walk(input logic [VA_W-1:0] va, input logic wr,
                          output logic got_done, output logic got_fault);
    reads = 0;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 0;
    got_done = 0; got_fault = 0;
    for (int i = 0; i < 300; i++) begin
      if (done || fault) break;
      @(negedge clk);
    end
    got_done = done; got_fault = fault;
    @(negedge clk);
    chk("R9 pulse ends", {62'b0, done, fault}, 64'd0);
  endtask

  task automatic load_root(input logic [19:0] fn);
    @(negedge clk);
    root_load = 1; root_frame = fn;
    @(negedge clk);
    root_load = 0;
  endtask

  task automatic t_reset();
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 busy after reset", busy, 0);
    chk("R9 no outcome after reset", {done, fault}, 0);
    chk("R4 no read while idle", mem_req_valid, 0);
  endtask

  task automatic t_read_hit();
    logic d, f;
    run_walk(mkva(5, 3, 1023, 'h123), 0, d, f);
    chk("R5 done", {d, f}, 2'b10);
    chk("R5 paddr", paddr, 32'hABCDE123);
    chk("R4 reads", reads, 3);
    chk("R2 level0 addr", rd_addr[0], {20'h00100, 10'd5, 2'b00});
    chk("R2 level1 addr", rd_addr[1], {20'h00200, 10'd3, 2'b00});
    chk("R2 level2 addr", rd_addr[2], {20'h00400, 10'd1023, 2'b00});
  endtask

  task automatic t_write();
    logic d, f;
    run_walk(mkva(5, 3, 1023, 'hFFF), 1, d, f);
    chk("R5 write ok", {d, f}, 2'b10);
    chk("R5 paddr max offset", paddr, 32'hABCDEFFF);
    run_walk(mkva(5, 3, 2, 0), 1, d, f);
    chk("R7 write ro leaf fault", {d, f}, 2'b01);
    chk("R7 fault level", flvl, 2);
    chk("R7 paddr held", paddr, 32'hABCDEFFF);
    run_walk(mkva(5, 3, 2, 'h40), 0, d, f);
    chk("R7 read ro leaf ok", {d, f}, 2'b10);
    chk("R7 paddr", paddr, 32'h12345040);
    run_walk(mkva(7, 1, 6, 8), 1, d, f);
    chk("R7 inner writable ignored", {d, f}, 2'b10);
    chk("R7 paddr inner ro", paddr, 32'h0F0F0008);
  endtask

  task automatic t_invalid();
    logic d, f;
    run_walk(mkva(9, 0, 0, 0), 0, d, f);
    chk("R6 level0 fault", {d, f}, 2'b01);
    chk("R6 level0 index", flvl, 0);
    chk("R6 level0 reads", reads, 1);
    run_walk(mkva(5, 4, 0, 0), 0, d, f);
    chk("R6 level1 fault", {d, f}, 2'b01);
    chk("R6 level1 index", flvl, 1);
    chk("R6 level1 reads", reads, 2);
  endtask

  task automatic t_stall();
    logic d, f;
    stall_cfg = 3; stall_left = 3; rsp_lat = 4;
    run_walk(mkva(5, 3, 1023, 'h7), 0, d, f);
    chk("R4 stalled done", {d, f}, 2'b10);
    chk("R4 stalled paddr", paddr, 32'hABCDE007);
    chk("R4 stalled reads", reads, 3);
    stall_cfg = 0; stall_left = 0; rsp_lat = 0;
  endtask

  task automatic t_busy();
    logic d, f;
    fork
      run_walk(mkva(5, 3, 1023, 'h55), 0, d, f);
      begin
        repeat (3) @(negedge clk);
        chk("R1 busy during walk", busy, 1);
        chk("R1 ready low during walk", req_ready, 0);
        req_valid = 1; req_vaddr = mkva(9, 0, 0, 0); req_write = 1;
        repeat (3) @(negedge clk);
        req_valid = 0;
      end
    join
    chk("R1 busy request ignored", {d, f}, 2'b10);
    chk("R1 first walk paddr", paddr, 32'hABCDE055);
    chk("R1 no extra reads", reads, 3);
    chk("R1 idle after walk", {busy, req_ready}, 2'b01);
  endtask

  task automatic t_root();
    logic d, f;
    load_root(20'h00600);
    run_walk(mkva(5, 3, 1023, 'h10), 0, d, f);
    chk("R8 new root used", paddr, 32'h55555010);
    chk("R8 root addr", rd_addr[0], {20'h00600, 10'd5, 2'b00});
    fork
      run_walk(mkva(5, 3, 1023, 'h20), 0, d, f);
      begin
        repeat (3) @(negedge clk);
        root_load = 1; root_frame = 20'h00100;
        @(negedge clk);
        root_load = 0;
      end
    join
    chk("R8 mid-walk load ignored", paddr, 32'h55555020);
    run_walk(mkva(5, 3, 1023, 'h30), 0, d, f);
    chk("R8 later walk uses reload", paddr, 32'hABCDE030);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    put(20'h00100, 5, ent(20'h00200, 1, 1));
    put(20'h00100, 7, ent(20'h00300, 0, 1));
    put(20'h00100, 9, ent(20'h00900, 1, 0));
    put(20'h00200, 3, ent(20'h00400, 1, 1));
    put(20'h00300, 1, ent(20'h00500, 1, 1));
    put(20'h00400, 1023, ent(20'hABCDE, 1, 1));
    put(20'h00400, 2, ent(20'h12345, 0, 1));
    put(20'h00500, 6, ent(20'h0F0F0, 1, 1));
    put(20'h00600, 5, ent(20'h00700, 1, 1));
    put(20'h00700, 3, ent(20'h00800, 1, 1));
    put(20'h00800, 1023, ent(20'h55555, 1, 1));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    load_root(20'h00100);
    t_read_hit();
    t_write();
    t_invalid();
    t_stall();
    t_busy();
    t_root();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule